// File: doc/BRIEF.md
# 64-bit Integer Execute Unit with 32-bit Word Operations

This block is the arithmetic and logic stage of a 64-bit RISC-V style integer pipeline. It is purely combinational. The caller supplies four things: a decoded operation code, two register operands, an immediate and the address of the instruction. The block returns the 64-bit value that is written back to the destination register. A select input replaces the second register operand with the immediate, which gives the register-immediate forms. A word flag turns add, subtract and the shifts into their 32-bit variants. Those variants read only the low half of their inputs and always give a sign-extended 32-bit answer.

The unit also builds the two upper-immediate results: the loaded upper constant, and the constant added to the instruction address. It does not raise exceptions. An immediate word shift whose amount field has bit 5 set is a reserved encoding. The block reports it on a flag and leaves the response to the caller.

Top module: `alu64_exec`

## Requirements
- R1: With operation code 0 (add) or 1 (subtract) and the word flag low, the result is the 64-bit sum or difference of operand A and the second operand, wrapping modulo 2^64. The second operand is `imm_i` when `imm_sel_i` is high and `src_b_i` otherwise.
- R2: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of operand A and the second operand. Codes 12 to 15 give a result of zero.
- R3: Code 5 (signed less-than) and code 6 (unsigned less-than) compare all 64 bits. They return 1 or 0 in bit 0, and bits 63:1 are zero.
- R4: Codes 7 (left shift), 8 (logical right) and 9 (arithmetic right) with the word flag low shift all 64 bits of operand A. The amount is bits [5:0] of the second operand, and every higher bit of it is ignored.
- R5: Add and subtract with the word flag high use only bits 31:0 of both operands. Bit 31 of the 32-bit result is copied into bits 63:32, and any overflow is dropped without any indication.
- R6: A word add of the immediate zero returns the sign extension of bits 31:0 of operand A.
- R7: Word shifts act only on bits 31:0 of operand A and take their amount from bits [4:0] of the second operand. The arithmetic right form fills vacated bits with the original bit 31, and the logical forms fill with zeros. The 32-bit result is then sign-extended to 64 bits.
- R8: For a right shift (code 8 or 9) with `imm_sel_i` high, bit 10 of `imm_i` selects the shift type (1 arithmetic, 0 logical) and the operation code does not.
- R9: `rsvd_o` is 1 exactly when the word flag and `imm_sel_i` are both high, the code is 7, 8 or 9, and bit 5 of `imm_i` is 1. It is 0 in every other case.
- R10: Code 10 (upper constant) returns `{imm_i[31:12], 12'b0}` sign-extended from bit 31. All other immediate bits are ignored.
- R11: Code 11 (address plus upper constant) returns `pc_i` plus the same sign-extended upper constant, modulo 2^64.
- R12: The word flag has no effect on codes 2 to 6, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 slt, 6 sltu, 7 sll, 8 srl, 9 sra, 10 upper constant, 11 address plus upper constant) |
| word_i | input | 1 | Selects the 32-bit word variant of add, subtract and shifts |
| imm_sel_i | input | 1 | Uses `imm_i` instead of `src_b_i` as the second operand |
| src_a_i | input | 64 | First register operand |
| src_b_i | input | 64 | Second register operand |
| imm_i | input | 64 | Sign-extended immediate, or upper immediate in bits 31:12 |
| pc_i | input | 64 | Address of the current instruction |
| result_o | output | 64 | Write-back value |
| rsvd_o | output | 1 | Reserved immediate word-shift encoding seen |

## Verification
All results and the reserved flag are combinational, so each one is valid in the same cycle as the inputs that produce it and needs no further clock edge. The bench drives a new input set just after a rising edge. It reads `result_o` and `rsvd_o` on the following falling edge, half a period later, once the inputs have settled and well away from the edge where the next set is applied. Every cycle therefore carries exactly one stimulus and one comparison, and no output is sampled while its inputs are changing.

// File: rtl/alu64_pkg.sv
// Package: operation codes shared by the execute unit and its sub-blocks.
// Assumes the decoder upstream has already mapped instructions onto these codes.
package alu64_pkg;
    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_SLT   = 4'd5,
        OP_SLTU  = 4'd6,
        OP_SLL   = 4'd7,
        OP_SRL   = 4'd8,
        OP_SRA   = 4'd9,
        OP_UPPER = 4'd10,
        OP_PCREL = 4'd11
    } alu_op_e;
endpackage

// File: rtl/alu64_addsub.sv
// Module: alu64_addsub
// Adds or subtracts two XLEN operands. In word mode only the low half of
// each operand counts, and the low-half sum is sign-extended to XLEN.
// Assumes XLEN is even. Overflow is discarded in both modes.
module alu64_addsub #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] lhs_i,
    input  logic [XLEN-1:0] rhs_i,
    input  logic            sub_i,
    input  logic            word_i,
    output logic [XLEN-1:0] sum_o
);
    localparam int WLEN = XLEN / 2;

    logic [XLEN-1:0] rhs_eff;
    logic [XLEN-1:0] raw_sum;

    // Form the two's-complement sum and apply word sign extension when asked.
    always_comb begin
        rhs_eff = sub_i ? ~rhs_i : rhs_i;
        raw_sum = lhs_i + rhs_eff + {{(XLEN-1){1'b0}}, sub_i};
        if (word_i) begin
            sum_o = {{(XLEN-WLEN){raw_sum[WLEN-1]}}, raw_sum[WLEN-1:0]};
        end else begin
            sum_o = raw_sum;
        end
    end

    // Word results carry bit WLEN-1 through the whole upper half (R5).
    always_comb begin
        if (word_i) begin
            a_r5_word_sext: assert (sum_o[XLEN-1:WLEN] == {(XLEN-WLEN){sum_o[WLEN-1]}})
                else $error("word add/sub result not sign-extended");
        end
    end
endmodule

// File: rtl/alu64_shift.sv
// Module: alu64_shift
// Barrel shifter for left, logical right and arithmetic right shifts. Full
// mode shifts XLEN bits by a log2(XLEN)-bit amount. Word mode shifts the low
// half by one bit less of amount and sign-extends the half-width result.
// Assumes XLEN is an even power of two.
module alu64_shift #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]         val_i,
    input  logic [$clog2(XLEN)-1:0] amt_i,
    input  logic                    right_i,
    input  logic                    arith_i,
    input  logic                    word_i,
    output logic [XLEN-1:0]         res_o
);
    localparam int WLEN = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);
    localparam int WSHW = SHW - 1;

    logic [XLEN-1:0] full_res;
    logic [WLEN-1:0] half_val;
    logic [WSHW-1:0] half_amt;
    logic [WLEN-1:0] half_res;

    // Full-width shift of all XLEN bits.
    always_comb begin
        if (!right_i) begin
            full_res = val_i << amt_i;
        end else if (arith_i) begin
            full_res = XLEN'($signed(val_i) >>> amt_i);
        end else begin
            full_res = val_i >> amt_i;
        end
    end

    // Half-width shift; the upper input half never enters.
    always_comb begin
        half_val = val_i[WLEN-1:0];
        half_amt = amt_i[WSHW-1:0];
        if (!right_i) begin
            half_res = half_val << half_amt;
        end else if (arith_i) begin
            half_res = WLEN'($signed(half_val) >>> half_amt);
        end else begin
            half_res = half_val >> half_amt;
        end
    end

    // Select the width and sign-extend word results.
    always_comb begin
        if (word_i) begin
            res_o = {{(XLEN-WLEN){half_res[WLEN-1]}}, half_res};
        end else begin
            res_o = full_res;
        end
    end

    // A zero amount leaves a full-width operand unchanged (R4).
    always_comb begin
        if (!word_i && amt_i == '0) begin
            a_r4_zero_amt: assert (res_o == val_i)
                else $error("zero shift altered operand");
        end
    end

    // Word shifts produce a sign-extended result (R7).
    always_comb begin
        if (word_i) begin
            a_r7_word_sext: assert (res_o[XLEN-1:WLEN] == {(XLEN-WLEN){res_o[WLEN-1]}})
                else $error("word shift result not sign-extended");
        end
    end
endmodule

// File: rtl/alu64_logic.sv
// Module: alu64_logic
// Bitwise AND/OR/XOR and signed/unsigned less-than on full XLEN operands.
// Codes outside its set give zero; the caller selects this output only for
// its own codes.
module alu64_logic
    import alu64_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  alu_op_e         op_i,
    input  logic [XLEN-1:0] lhs_i,
    input  logic [XLEN-1:0] rhs_i,
    output logic [XLEN-1:0] res_o
);
    logic lt_signed;
    logic lt_unsigned;

    // Compare full width both ways.
    always_comb begin
        lt_signed   = $signed(lhs_i) < $signed(rhs_i);
        lt_unsigned = lhs_i < rhs_i;
    end

    // Pick the bitwise or compare answer.
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = lhs_i & rhs_i;
            OP_OR:   res_o = lhs_i | rhs_i;
            OP_XOR:  res_o = lhs_i ^ rhs_i;
            OP_SLT:  res_o = {{(XLEN-1){1'b0}}, lt_signed};
            OP_SLTU: res_o = {{(XLEN-1){1'b0}}, lt_unsigned};
            default: res_o = '0;
        endcase
    end

    // Equal operands are never less-than either way (R3).
    always_comb begin
        if ((op_i == OP_SLT || op_i == OP_SLTU) && lhs_i == rhs_i) begin
            a_r3_equal_false: assert (res_o == '0)
                else $error("compare of equal operands returned nonzero");
        end
    end
endmodule

// File: rtl/alu64_exec.sv
// Module: alu64_exec
// Combinational integer execute unit. Selects the second operand, builds
// the sign-extended upper constant, steers the operands to the adder,
// shifter or logic unit, and raises a flag for reserved immediate word
// shifts. Assumes the caller has decoded the instruction into op_i and a
// sign-extended immediate (upper immediate in bits 31:12).
module alu64_exec
    import alu64_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0]      op_i,
    input  logic            word_i,
    input  logic            imm_sel_i,
    input  logic [XLEN-1:0] src_a_i,
    input  logic [XLEN-1:0] src_b_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] result_o,
    output logic            rsvd_o
);
    localparam int WLEN   = XLEN / 2;
    localparam int SHW    = $clog2(XLEN);
    localparam int UPLO   = 12;
    localparam int ARBIT  = 10;

    alu_op_e         op;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] upper_k;
    logic            is_shift;
    logic            is_right;
    logic            is_arith;
    logic            is_addsub;
    logic [XLEN-1:0] add_lhs;
    logic [XLEN-1:0] add_rhs;
    logic            add_word;
    logic [XLEN-1:0] add_res;
    logic [XLEN-1:0] sh_res;
    logic [XLEN-1:0] lg_res;

    // Decode the code and build the shared operands.
    always_comb begin
        op        = alu_op_e'(op_i);
        opnd_b    = imm_sel_i ? imm_i : src_b_i;
        upper_k   = {{(XLEN-WLEN){imm_i[WLEN-1]}}, imm_i[WLEN-1:UPLO], {UPLO{1'b0}}};
        is_shift  = (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
        is_right  = (op == OP_SRL) || (op == OP_SRA);
        is_arith  = imm_sel_i ? imm_i[ARBIT] : (op == OP_SRA);
        is_addsub = (op == OP_ADD) || (op == OP_SUB);
        add_lhs   = (op == OP_PCREL) ? pc_i : src_a_i;
        add_rhs   = (op == OP_PCREL) ? upper_k : opnd_b;
        add_word  = word_i && is_addsub;
    end

    alu64_addsub #(.XLEN(XLEN)) u_addsub (
        .lhs_i  (add_lhs),
        .rhs_i  (add_rhs),
        .sub_i  (op == OP_SUB),
        .word_i (add_word),
        .sum_o  (add_res)
    );

    alu64_shift #(.XLEN(XLEN)) u_shift (
        .val_i   (src_a_i),
        .amt_i   (opnd_b[SHW-1:0]),
        .right_i (is_right),
        .arith_i (is_arith),
        .word_i  (word_i),
        .res_o   (sh_res)
    );

    alu64_logic #(.XLEN(XLEN)) u_logic (
        .op_i  (op),
        .lhs_i (src_a_i),
        .rhs_i (opnd_b),
        .res_o (lg_res)
    );

    // Steer the selected unit's answer to the write-back value.
    always_comb begin
        case (op)
            OP_ADD, OP_SUB, OP_PCREL:               result_o = add_res;
            OP_SLL, OP_SRL, OP_SRA:                 result_o = sh_res;
            OP_AND, OP_OR, OP_XOR, OP_SLT, OP_SLTU: result_o = lg_res;
            OP_UPPER:                               result_o = upper_k;
            default:                                result_o = '0;
        endcase
    end

    // Flag immediate word shifts whose amount field has its top bit set.
    always_comb begin
        rsvd_o = word_i && imm_sel_i && is_shift && imm_i[SHW-1];
    end

    // Compare results occupy bit 0 only (R3).
    always_comb begin
        if (op == OP_SLT || op == OP_SLTU) begin
            a_r3_bit0_only: assert (result_o[XLEN-1:1] == '0)
                else $error("compare result has high bits set");
        end
    end

    // Upper constant has its low twelve bits clear and is sign-extended (R10).
    always_comb begin
        if (op == OP_UPPER) begin
            a_r10_upper_shape: assert (result_o[UPLO-1:0] == '0 &&
                                       result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}})
                else $error("upper constant malformed");
        end
    end

    // Reserved flag only for immediate word shifts (R9).
    always_comb begin
        if (rsvd_o) begin
            a_r9_rsvd_context: assert (word_i && imm_sel_i && is_shift)
                else $error("reserved flag outside immediate word shift");
        end
    end

    // Word add/sub output from the top is sign-extended from bit 31 (R5).
    always_comb begin
        if (word_i && is_addsub) begin
            a_r5_top_sext: assert (result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}})
                else $error("word result at top not sign-extended");
        end
    end
endmodule

// File: tb/tb_alu64_exec.sv
// Bench: drives alu64_exec with directed corners and seeded random input
// sets, and compares each result with an independent model built from the
// requirements. One input set per 4 ns cycle; outputs are read on the
// falling edge.
module tb_alu64_exec;
    logic        clk = 1'b0;
    logic [3:0]  op_i = '0;
    logic        word_i = 1'b0;
    logic        imm_sel_i = 1'b0;
    logic [63:0] src_a_i = '0;
    logic [63:0] src_b_i = '0;
    logic [63:0] imm_i = '0;
    logic [63:0] pc_i = '0;
    logic [63:0] result_o;
    logic        rsvd_o;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    alu64_exec dut (
        .op_i      (op_i),
        .word_i    (word_i),
        .imm_sel_i (imm_sel_i),
        .src_a_i   (src_a_i),
        .src_b_i   (src_b_i),
        .imm_i     (imm_i),
        .pc_i      (pc_i),
        .result_o  (result_o),
        .rsvd_o    (rsvd_o)
    );

    // Sign-extend a 32-bit value.
    function automatic logic [63:0] sx32(input logic [31:0] x);
        return {{32{x[31]}}, x};
    endfunction

    // Model of the write-back value from the requirements.
    function automatic logic [63:0] model(input logic [3:0] op, input logic w, input logic isel,
                                          input logic [63:0] a, input logic [63:0] bv,
                                          input logic [63:0] imm, input logic [63:0] pc);
        logic [63:0] b;
        logic [63:0] u;
        logic [31:0] t;
        logic        ar;
        b  = isel ? imm : bv;
        u  = sx32({imm[31:12], 12'h000});
        ar = isel ? imm[10] : (op == 4'd9);
        case (op)
            4'd0: begin t = a[31:0] + b[31:0]; return w ? sx32(t) : a + b; end
            4'd1: begin t = a[31:0] - b[31:0]; return w ? sx32(t) : a - b; end
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return {63'd0, $signed(a) < $signed(b)};
            4'd6: return {63'd0, a < b};
            4'd7: begin t = a[31:0] << b[4:0]; return w ? sx32(t) : a << b[5:0]; end
            4'd8, 4'd9: begin
                if (w) begin
                    if (ar) t = $signed(a[31:0]) >>> b[4:0];
                    else    t = a[31:0] >> b[4:0];
                    return sx32(t);
                end
                if (ar) return $signed(a) >>> b[5:0];
                return a >> b[5:0];
            end
            4'd10: return u;
            4'd11: return pc + u;
            default: return 64'd0;
        endcase
    endfunction

    // Model of the reserved-encoding flag.
    function automatic logic model_rsvd(input logic [3:0] op, input logic w, input logic isel,
                                        input logic [63:0] imm);
        return w && isel && (op == 4'd7 || op == 4'd8 || op == 4'd9) && imm[5];
    endfunction

    // Requirement tag for a random input set.
    function automatic string tag_of(input logic [3:0] op, input logic w, input logic isel);
        case (op)
            4'd0, 4'd1: return w ? "R5" : "R1";
            4'd2, 4'd3, 4'd4: return w ? "R12" : "R2";
            4'd5, 4'd6: return w ? "R12" : "R3";
            4'd7, 4'd8, 4'd9: return w ? "R7" : (isel ? "R8" : "R4");
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R2";
        endcase
    endfunction

    // Apply one input set, compare result and flag against the given values.
    task automatic run(input string tag, input logic [3:0] op, input logic w, input logic isel,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] imm,
                       input logic [63:0] pc, input logic [63:0] exp_r, input logic exp_f);
        @(posedge clk);
        op_i = op; word_i = w; imm_sel_i = isel;
        src_a_i = a; src_b_i = b; imm_i = imm; pc_i = pc;
        @(negedge clk);
        total++;
        if (result_o !== exp_r || rsvd_o !== exp_f) begin
            bad++;
            $display("FAIL %s op=%0d w=%0b isel=%0b got=%h/%0b exp=%h/%0b",
                     tag, op, w, isel, result_o, rsvd_o, exp_r, exp_f);
        end
    endtask

    // Apply one input set and compare against the model.
    task automatic run_m(input string tag, input logic [3:0] op, input logic w, input logic isel,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] imm,
                         input logic [63:0] pc);
        run(tag, op, w, isel, a, b, imm, pc,
            model(op, w, isel, a, b, imm, pc), model_rsvd(op, w, isel, imm));
    endtask

    // Draw an operand, often a corner value or one with garbage upper bits.
    function automatic logic [63:0] pick_val();
        case ($urandom % 8)
            0: return 64'h0000_0000_7FFF_FFFF;
            1: return 64'h0000_0000_8000_0000;
            2: return {$urandom, 32'h7FFF_FFFF};
            3: return {$urandom, 32'h8000_0000};
            4: return 64'hFFFF_FFFF_FFFF_FFFF;
            5: return 64'h8000_0000_0000_0000;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    // Draw a shift amount field, favouring 0, 31, 32 and 63, with high garbage.
    function automatic logic [63:0] pick_amt();
        logic [63:0] g;
        g = {$urandom, $urandom};
        case ($urandom % 6)
            0: return {g[63:6], 6'd0};
            1: return {g[63:6], 6'd31};
            2: return {g[63:6], 6'd32};
            3: return {g[63:6], 6'd63};
            default: return g;
        endcase
    endfunction

    // Watchdog: a hung run still ends with a failure and the summary.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        // Idle inputs: add of zeros gives zero, no flag.
        run("R1", 4'd0, 1'b0, 1'b0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 1'b0);
        // R1: 64-bit wrap and immediate operand select.
        run("R1", 4'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd99, 64'd0, 64'd0, 1'b0);
        run("R1", 4'd1, 1'b0, 1'b1, 64'd5, 64'd1, 64'd7, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
        // R5: word add overflow and garbage upper bits.
        run("R5", 4'd0, 1'b1, 1'b0, 64'hDEAD_BEEF_7FFF_FFFF, 64'h1234_0000_0000_0001, 64'd0, 64'd0,
            64'hFFFF_FFFF_8000_0000, 1'b0);
        run("R5", 4'd1, 1'b1, 1'b0, 64'h0000_0000_8000_0000, 64'h5555_5555_0000_0001, 64'd0, 64'd0,
            64'h0000_0000_7FFF_FFFF, 1'b0);
        // R6: word add of immediate zero is a sign extend.
        run("R6", 4'd0, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hFFFF, 64'd0, 64'd0,
            64'hFFFF_FFFF_89AB_CDEF, 1'b0);
        // R3: signed versus unsigned on the sign bit.
        run("R3", 4'd5, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 64'd1, 64'd0, 64'd0, 64'd1, 1'b0);
        run("R3", 4'd6, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 64'd1, 64'd0, 64'd0, 64'd0, 1'b0);
        // R4: amount from bits 5:0 only.
        run("R4", 4'd7, 1'b0, 1'b0, 64'd1, 64'hFFFF_FFFF_FFFF_FFC0 | 64'd63, 64'd0, 64'd0,
            64'h8000_0000_0000_0000, 1'b0);
        run("R4", 4'd9, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 64'd32, 64'd0, 64'd0,
            64'hFFFF_FFFF_8000_0000, 1'b0);
        // R7: word shifts, amounts 0 and 31, arithmetic and logical fill.
        run("R7", 4'd9, 1'b1, 1'b0, 64'h0000_0000_8000_0000, 64'd31, 64'd0, 64'd0,
            64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run("R7", 4'd8, 1'b1, 1'b0, 64'h0000_0000_8000_0000, 64'd31, 64'd0, 64'd0, 64'd1, 1'b0);
        run("R7", 4'd8, 1'b1, 1'b0, 64'hAAAA_AAAA_8000_0000, 64'd32, 64'd0, 64'd0,
            64'hFFFF_FFFF_8000_0000, 1'b0);
        run("R7", 4'd7, 1'b1, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'd31, 64'd0, 64'd0,
            64'hFFFF_FFFF_8000_0000, 1'b0);
        // R8: immediate bit 10 overrides the code.
        run("R8", 4'd8, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'd0, 64'h400 | 64'd4, 64'd0,
            64'hF800_0000_0000_0000, 1'b0);
        run("R8", 4'd9, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'd0, 64'd4, 64'd0,
            64'h0800_0000_0000_0000, 1'b0);
        // R9: reserved flag only for immediate word shifts with bit 5 set.
        run_m("R9", 4'd7, 1'b1, 1'b1, 64'd3, 64'd0, 64'd33, 64'd0);
        run("R9", 4'd7, 1'b1, 1'b1, 64'd3, 64'd0, 64'd33, 64'd0, 64'd6, 1'b1);
        run("R9", 4'd7, 1'b1, 1'b0, 64'd3, 64'd33, 64'd33, 64'd0, 64'd6, 1'b0);
        run("R9", 4'd7, 1'b0, 1'b1, 64'd3, 64'd0, 64'd33, 64'd0, 64'd6 << 32, 1'b0);
        run("R9", 4'd0, 1'b1, 1'b1, 64'd3, 64'd0, 64'd32, 64'd0, 64'd35, 1'b0);
        // R10: upper constant with negative bit 31, other bits ignored.
        run("R10", 4'd10, 1'b0, 1'b0, 64'd9, 64'd9, 64'h1234_5678_8000_0FFF, 64'd0,
            64'hFFFF_FFFF_8000_0000, 1'b0);
        // R11: address plus upper constant.
        run("R11", 4'd11, 1'b0, 1'b0, 64'd9, 64'd9, 64'hFFFF_F000, 64'h0000_0000_0001_0000,
            64'h0000_0000_0000_F000, 1'b0);
        // R12: word flag does not alter logic, compare and upper ops.
        run("R12", 4'd4, 1'b1, 1'b0, 64'hF0F0_0000_0000_0000, 64'h0F0F_0000_0000_0001, 64'd0, 64'd0,
            64'hFFFF_0000_0000_0001, 1'b0);
        run("R12", 4'd6, 1'b1, 1'b0, 64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF, 64'd0, 64'd0,
            64'd0, 1'b0);
        // R2: unused codes give zero.
        run("R2", 4'd13, 1'b0, 1'b0, 64'hFFFF, 64'hFFFF, 64'hFFFF, 64'hFFFF, 64'd0, 1'b0);
        // Random mix against the model.
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  rop;
            logic        rw;
            logic        ris;
            logic [63:0] ra;
            logic [63:0] rb;
            logic [63:0] rimm;
            logic [63:0] rpc;
            rop  = 4'($urandom % 12);
            rw   = 1'($urandom);
            ris  = 1'($urandom);
            ra   = pick_val();
            rb   = (rop >= 4'd7 && rop <= 4'd9) ? pick_amt() : pick_val();
            rimm = (rop >= 4'd7 && rop <= 4'd9) ? pick_amt() : pick_val();
            rpc  = {$urandom, $urandom};
            run_m(tag_of(rop, rw, ris), rop, rw, ris, ra, rb, rimm, rpc);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule